// File: doc/BRIEF.md
# ADC Step Sequencer

This block drives the front end of a successive-approximation converter from a bank of sixteen step slots. Each slot carries a 3-bit input channel number, an open delay, a sample delay and a continuous/one-shot mode bit. A per-slot enable register is set by request pulses. While the block is enabled, it starts at the lowest enabled slot and works upward. For each slot it drives the channel select, waits out the open delay and then holds the start-of-conversion strobe for the sample window. After that it waits for the front end's end-of-conversion pulse. The converted 12-bit value is then presented together with the slot number and the channel number.

The analog front end lies outside the block. It is seen only through its end-of-conversion pulse and its data bus. When one pass over the enabled slots finishes, an end-of-sequence pulse is raised. That pulse only marks the end of the pass and says nothing about data storage. Slots marked one-shot drop their enable bit once they have converted. Slots marked continuous keep it, so the sequencer comes round again from the lowest enabled slot.

Top module: `adc_step_seq`

## Requirements
- R1: After reset the sequencer is idle: soc_o, res_valid_o and eos_o are low and ch_sel_o is 0.
- R2: Within a pass, slots are converted in ascending slot number, starting at the lowest enabled slot, and slots with a clear enable bit are skipped. ch_sel_o carries the active slot's channel from the first cycle of that slot until its conversion ends, and is 0 while idle.
- R3: While no enable bit is set, the sequencer stays idle and never asserts soc_o.
- R4: soc_o rises N cycles after the first cycle of a slot, where N is the slot's open delay. With an open delay of 0, soc_o is high in the slot's first cycle.
- R5: soc_o stays high for exactly the slot's sample delay plus one cycles.
- R6: After the sample window the sequencer waits for afe_eoc_i. A pulse on afe_eoc_i while the sequencer is not waiting (idle, open or sample) produces no result.
- R7: In the cycle after afe_eoc_i is accepted, res_valid_o is high for one cycle. In that cycle res_data_o holds afe_data_i, res_step_o holds the 4-bit slot number and res_ch_o holds the 3-bit channel. The next enabled slot starts in that same cycle.
- R8: eos_o pulses together with the result of the last enabled slot of a pass, exactly once per pass, and the sequencer is idle in that cycle.
- R9: A slot whose mode bit is 1 (continuous) keeps its enable bit. After end-of-sequence the sequencer restarts from the lowest enabled slot after one idle cycle.
- R10: A slot whose mode bit is 0 (one-shot) has its enable bit cleared when its conversion completes. A bit of step_set_i sets the matching enable bit, and a set in the same cycle as a clear wins.
- R11: When en_i is low at a clock edge, the sequencer is idle in the next cycle with soc_o low, and no result or end-of-sequence is produced for the aborted pass. Enable bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low aborts and holds idle |
| step_set_i | input | 16 | Per-slot enable set request |
| step_cont_i | input | 16 | Per-slot mode: 1 continuous, 0 one-shot |
| step_ch_i | input | 48 | Per-slot channel, slot k at bits [3k+2:3k] |
| step_open_i | input | 128 | Per-slot open delay, slot k at bits [8k+7:8k] |
| step_smp_i | input | 128 | Per-slot sample delay, slot k at bits [8k+7:8k] |
| afe_eoc_i | input | 1 | End-of-conversion pulse from the front end |
| afe_data_i | input | 12 | Conversion value from the front end |
| ch_sel_o | output | 3 | Channel select to the front end |
| soc_o | output | 1 | Start-of-conversion strobe |
| res_valid_o | output | 1 | Result valid pulse |
| res_data_o | output | 12 | Result value |
| res_step_o | output | 4 | Slot number of the result |
| res_ch_o | output | 3 | Channel number of the result |
| eos_o | output | 1 | End-of-sequence pulse |

## Verification
The first pattern enables nothing, which shows whether an empty enable register really leaves the sequencer parked. The second is a sparse one-shot set: slot 15, a zero open delay and a long sample window. It separates correct ascending skip-order and the top-slot boundary from an off-by-one in the window counts, and shows that one-shot slots fall silent afterwards. The third mixes continuous and one-shot slots and re-sets a one-shot slot exactly as it completes, which tells wrap-around and set-over-clear priority apart. The fourth drops the enable mid-sample, so a late end-of-conversion arrives while idle. That shows the abort path and the rejection of a stray end-of-conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OPEN   = 2'd1,
    ST_SAMPLE = 2'd2,
    ST_CONV   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_step_pick.sv
// Lowest set request at or above base_i.
module adc_step_pick #(
  parameter int N      = 16,
  parameter int IDX_W  = $clog2(N),
  parameter int BASE_W = IDX_W + 1
) (
  input  logic [N-1:0]      req_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && (i >= int'(base_i))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_step_timer.sv
module adc_step_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  a_r5_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/adc_step_enables.sv
module adc_step_enables #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q & ~clr_i) | set_i;
  end

  assign en_o = en_q;

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((en_q & $past(set_i)) == $past(set_i)));
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((en_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq
  import adc_seq_pkg::*;
#(
  parameter int N_STEPS = 16,
  parameter int N_CH    = 8,
  parameter int RES_W   = 12,
  parameter int DLY_W   = 8,
  localparam int STEP_W = $clog2(N_STEPS),
  localparam int CH_W   = $clog2(N_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [N_STEPS-1:0]       step_set_i,
  input  logic [N_STEPS-1:0]       step_cont_i,
  input  logic [N_STEPS*CH_W-1:0]  step_ch_i,
  input  logic [N_STEPS*DLY_W-1:0] step_open_i,
  input  logic [N_STEPS*DLY_W-1:0] step_smp_i,
  input  logic                     afe_eoc_i,
  input  logic [RES_W-1:0]         afe_data_i,
  output logic [CH_W-1:0]          ch_sel_o,
  output logic                     soc_o,
  output logic                     res_valid_o,
  output logic [RES_W-1:0]         res_data_o,
  output logic [STEP_W-1:0]        res_step_o,
  output logic [CH_W-1:0]          res_ch_o,
  output logic                     eos_o
);
  localparam int BASE_W = STEP_W + 1;

  logic [CH_W-1:0]  ch_arr   [N_STEPS];
  logic [DLY_W-1:0] open_arr [N_STEPS];
  logic [DLY_W-1:0] smp_arr  [N_STEPS];

  for (genvar g = 0; g < N_STEPS; g++) begin : g_cfg
    assign ch_arr[g]   = step_ch_i[g*CH_W +: CH_W];
    assign open_arr[g] = step_open_i[g*DLY_W +: DLY_W];
    assign smp_arr[g]  = step_smp_i[g*DLY_W +: DLY_W];
  end

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] cur_q, cur_d;
  logic [N_STEPS-1:0] en_q, clr_mask;
  logic              tmr_load, tmr_zero;
  logic [DLY_W-1:0]  tmr_val;
  logic              rv_d, eos_d;
  logic              first_found, next_found;
  logic [STEP_W-1:0] first_idx, next_idx;
  logic              launch;
  logic [STEP_W-1:0] launch_idx;
  logic [BASE_W-1:0] next_base;

  assign next_base = {1'b0, cur_q} + 1'b1;

  adc_step_enables #(.N(N_STEPS)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (step_set_i),
    .clr_i (clr_mask),
    .en_o  (en_q)
  );

  adc_step_pick #(.N(N_STEPS)) u_pick_first (
    .req_i  (en_q),
    .base_i ('0),
    .found_o(first_found),
    .idx_o  (first_idx)
  );

  adc_step_pick #(.N(N_STEPS)) u_pick_next (
    .req_i  (en_q),
    .base_i (next_base),
    .found_o(next_found),
    .idx_o  (next_idx)
  );

  adc_step_timer #(.W(DLY_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    clr_mask   = '0;
    rv_d       = 1'b0;
    eos_d      = 1'b0;
    launch     = 1'b0;
    launch_idx = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (first_found) begin
          launch     = 1'b1;
          launch_idx = first_idx;
        end
      end
      ST_OPEN: begin
        if (tmr_zero) begin
          state_d  = ST_SAMPLE;
          tmr_load = 1'b1;
          tmr_val  = smp_arr[cur_q];
        end
      end
      ST_SAMPLE: begin
        if (tmr_zero) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (afe_eoc_i) begin
          rv_d = 1'b1;
          if (!step_cont_i[cur_q]) clr_mask[cur_q] = 1'b1;
          if (next_found) begin
            launch     = 1'b1;
            launch_idx = next_idx;
          end else begin
            state_d = ST_IDLE;
            eos_d   = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (launch) begin
      cur_d    = launch_idx;
      tmr_load = 1'b1;
      if (open_arr[launch_idx] != '0) begin
        state_d = ST_OPEN;
        tmr_val = open_arr[launch_idx] - 1'b1;
      end else begin
        state_d = ST_SAMPLE;
        tmr_val = smp_arr[launch_idx];
      end
    end

    if (!en_i) begin
      state_d  = ST_IDLE;
      rv_d     = 1'b0;
      eos_d    = 1'b0;
      clr_mask = '0;
      tmr_load = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      res_valid_o <= 1'b0;
      eos_o       <= 1'b0;
      res_data_o  <= '0;
      res_step_o  <= '0;
      res_ch_o    <= '0;
    end else begin
      state_q     <= state_d;
      cur_q       <= cur_d;
      res_valid_o <= rv_d;
      eos_o       <= eos_d;
      if (rv_d) begin
        res_data_o <= afe_data_i;
        res_step_o <= cur_q;
        res_ch_o   <= ch_arr[cur_q];
      end
    end
  end

  assign soc_o    = (state_q == ST_SAMPLE);
  assign ch_sel_o = (state_q == ST_IDLE) ? '0 : ch_arr[cur_q];

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  a_r8_eos_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |-> (res_valid_o && state_q == ST_IDLE));
  a_r11_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE && !soc_o && !res_valid_o && !eos_o));
  a_r5_soc_channel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soc_o && $past(soc_o)) |-> $stable(ch_sel_o));
  a_r3_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && en_q == '0) |=> (state_q == ST_IDLE));
  a_r6_wait_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && !afe_eoc_i && en_i) |=> (state_q == ST_CONV));
endmodule

// File: tb/tb_adc_step_seq.sv
module tb_adc_step_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [NS-1:0] tb_set = '0;
  logic [NS-1:0] rs_set = '0;
  logic [NS-1:0] step_set_i;
  logic [NS-1:0] step_cont_i = '0;
  logic [2:0] cfg_ch [NS];
  logic [7:0] cfg_open [NS];
  logic [7:0] cfg_smp [NS];
  logic [NS*3-1:0] step_ch_i;
  logic [NS*8-1:0] step_open_i, step_smp_i;
  logic afe_eoc_i = 1'b0;
  logic [11:0] afe_data_i = '0;
  logic [2:0] ch_sel_o;
  logic soc_o, res_valid_o, eos_o;
  logic [11:0] res_data_o;
  logic [3:0] res_step_o;
  logic [2:0] res_ch_o;

  assign step_set_i = tb_set | rs_set;
  for (genvar g = 0; g < NS; g++) begin : g_pack
    assign step_ch_i[g*3 +: 3]   = cfg_ch[g];
    assign step_open_i[g*8 +: 8] = cfg_open[g];
    assign step_smp_i[g*8 +: 8]  = cfg_smp[g];
  end

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adc_step_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .step_set_i(step_set_i), .step_cont_i(step_cont_i),
    .step_ch_i(step_ch_i), .step_open_i(step_open_i), .step_smp_i(step_smp_i),
    .afe_eoc_i(afe_eoc_i), .afe_data_i(afe_data_i),
    .ch_sel_o(ch_sel_o), .soc_o(soc_o), .res_valid_o(res_valid_o),
    .res_data_o(res_data_o), .res_step_o(res_step_o), .res_ch_o(res_ch_o),
    .eos_o(eos_o)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 open, 2 sample, 3 convert
  int m_st, m_cur, m_cnt, m_rstep, m_rch, m_rdata;
  bit m_rv, m_eos;
  bit [NS-1:0] m_en;
  always @(posedge clk_i or negedge rst_ni) begin
    int nst, ncur, ncnt, lidx;
    bit [NS-1:0] clr;
    if (!rst_ni) begin
      m_st = 0; m_cur = 0; m_cnt = 0; m_en = '0;
      m_rv = 0; m_eos = 0; m_rstep = 0; m_rch = 0; m_rdata = 0;
    end else begin
      nst = m_st; ncur = m_cur; ncnt = (m_cnt > 0) ? m_cnt - 1 : 0;
      lidx = -1; clr = '0; m_rv = 0; m_eos = 0;
      if (!en_i) nst = 0;
      else begin
        case (m_st)
          0: for (int k = NS - 1; k >= 0; k--) if (m_en[k]) lidx = k;
          1: if (m_cnt == 0) begin nst = 2; ncnt = cfg_smp[m_cur]; end
          2: if (m_cnt == 0) nst = 3;
          default: if (afe_eoc_i) begin
            m_rv = 1; m_rstep = m_cur; m_rch = cfg_ch[m_cur]; m_rdata = afe_data_i;
            if (!step_cont_i[m_cur]) clr[m_cur] = 1'b1;
            for (int k = NS - 1; k > m_cur; k--) if (m_en[k]) lidx = k;
            if (lidx < 0) begin nst = 0; m_eos = 1; end
          end
        endcase
        if (lidx >= 0) begin
          ncur = lidx;
          if (cfg_open[lidx] != 0) begin nst = 1; ncnt = cfg_open[lidx] - 1; end
          else begin nst = 2; ncnt = cfg_smp[lidx]; end
        end
      end
      m_st = nst; m_cur = ncur; m_cnt = ncnt;
      m_en = (m_en & ~clr) | step_set_i;
    end
  end

  // front end stand-in, per-cycle compare and counters
  int afe_cnt = 0, afe_seq = 0;
  bit prev_soc = 0;
  bit rs_arm = 0;
  int rs_step = 0;
  int res_cnt [NS];
  int eos_cnt = 0, soc_cnt = 0, res_total = 0, last_step = -1;
  bit order_bad = 0;
  bit run_cmp = 0;

  always @(negedge clk_i) begin
    if (run_cmp) begin
      chk(soc_o === (m_st == 2), "R4 soc", soc_o, m_st == 2);
      chk(ch_sel_o === ((m_st == 0) ? 3'd0 : cfg_ch[m_cur]), "R2 ch_sel",
          ch_sel_o, (m_st == 0) ? 0 : cfg_ch[m_cur]);
      chk(res_valid_o === m_rv, "R7 valid", res_valid_o, m_rv);
      if (m_rv && res_valid_o) begin
        chk(res_step_o == m_rstep[3:0], "R7 step", res_step_o, m_rstep);
        chk(res_ch_o == m_rch[2:0], "R7 channel", res_ch_o, m_rch);
        chk(res_data_o == m_rdata[11:0], "R7 data", res_data_o, m_rdata);
      end
      chk(eos_o === m_eos, "R8 eos", eos_o, m_eos);
    end
    if (soc_o) soc_cnt++;
    if (res_valid_o) begin
      res_cnt[res_step_o]++;
      res_total++;
      if (int'(res_step_o) <= last_step) order_bad = 1;
      last_step = res_step_o;
    end
    if (eos_o) begin eos_cnt++; last_step = -1; end
    rs_set = '0;
    afe_eoc_i = 1'b0;
    if (afe_cnt > 0) begin
      afe_cnt--;
      if (afe_cnt == 0) begin
        afe_eoc_i = 1'b1;
        afe_seq++;
        afe_data_i = 12'(afe_seq * 37 + 5);
        if (rs_arm && m_st == 3 && m_cur == rs_step) begin
          rs_set[rs_step] = 1'b1;
          rs_arm = 0;
        end
      end
    end
    if (prev_soc && !soc_o) afe_cnt = 13;
    prev_soc = soc_o;
  end

  task automatic clear_counts();
    for (int k = 0; k < NS; k++) res_cnt[k] = 0;
    eos_cnt = 0; soc_cnt = 0; res_total = 0; order_bad = 0; last_step = -1;
  endtask

  task automatic pulse_set(input logic [NS-1:0] m);
    @(negedge clk_i); tb_set = m;
    @(negedge clk_i); tb_set = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NS; k++) begin
      cfg_ch[k] = 3'((k * 3) % 8);
      cfg_open[k] = 8'(k % 3);
      cfg_smp[k] = 8'(k % 2);
      res_cnt[k] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(soc_o === 1'b0, "R1 soc", soc_o, 0);
    chk(res_valid_o === 1'b0, "R1 valid", res_valid_o, 0);
    chk(eos_o === 1'b0, "R1 eos", eos_o, 0);
    chk(ch_sel_o === 3'd0, "R1 ch_sel", ch_sel_o, 0);
    run_cmp = 1;

    // R3 nothing enabled
    en_i = 1'b1;
    clear_counts();
    repeat (60) @(negedge clk_i);
    chk(soc_cnt == 0, "R3 soc count", soc_cnt, 0);
    chk(res_total == 0, "R3 results", res_total, 0);

    // R2 sparse one-shot pass, zero open delay, top slot
    cfg_open[2] = 8'd0;  cfg_smp[2] = 8'd0;
    cfg_open[9] = 8'd4;  cfg_smp[9] = 8'd5;
    cfg_open[15] = 8'd1; cfg_smp[15] = 8'd2;
    clear_counts();
    pulse_set(16'h8204);
    repeat (200) @(negedge clk_i);
    chk(res_cnt[2] == 1, "R2 slot2 once", res_cnt[2], 1);
    chk(res_cnt[9] == 1, "R2 slot9 once", res_cnt[9], 1);
    chk(res_cnt[15] == 1, "R2 slot15 once", res_cnt[15], 1);
    chk(res_total == 3, "R2 skip others", res_total, 3);
    chk(!order_bad, "R2 ascending", order_bad, 0);
    chk(eos_cnt == 1, "R8 one eos", eos_cnt, 1);
    chk(soc_cnt == 10, "R5 soc cycles", soc_cnt, 10);
    clear_counts();
    repeat (100) @(negedge clk_i);
    chk(res_total == 0, "R10 one-shot cleared", res_total, 0);

    // R9 continuous mix, R10 set beats clear
    step_cont_i = '0;
    step_cont_i[4] = 1'b1;
    step_cont_i[11] = 1'b1;
    rs_step = 7; rs_arm = 1;
    clear_counts();
    pulse_set(16'h0890);
    repeat (400) @(negedge clk_i);
    chk(res_cnt[7] == 2, "R10 re-set slot7", res_cnt[7], 2);
    chk(eos_cnt >= 4, "R9 repeated passes", eos_cnt, 4);
    chk(res_cnt[4] >= eos_cnt, "R9 slot4 each pass", res_cnt[4], eos_cnt);
    chk(!order_bad, "R2 ascending mix", order_bad, 0);

    // R11 abort in sample, R6 stray eoc while idle
    while (m_st != 2) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(soc_o === 1'b0, "R11 soc low", soc_o, 0);
    chk(ch_sel_o === 3'd0, "R11 idle", ch_sel_o, 0);
    clear_counts();
    repeat (40) @(negedge clk_i);
    chk(res_total == 0, "R6 stray eoc ignored", res_total, 0);
    chk(eos_cnt == 0, "R11 no eos", eos_cnt, 0);
    en_i = 1'b1;
    while (res_total == 0) @(negedge clk_i);
    chk(last_step == 4, "R9 restart lowest", last_step, 4);
    repeat (100) @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule